// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

A bank of general-purpose pins that software controls through a small word-addressed register interface. For each pin, software can read the synchronised input level, set an output value and choose whether the pin drives. Each pin can also flag an interrupt on its rising edges, its falling edges or both. Detected edges latch into sticky event bits. A write of 1 clears an event bit. One interrupt line goes to the interrupt controller.

Any subset of the pins can be handed to an alternate peripheral. For a handed-over pin, the peripheral supplies the output value and the drive enable. The peripheral always sees the synchronised input level of every pin. Edge detection runs on all pins, whichever owner they have.

Register map (word index on `bus_addr`, bit i belongs to pin i):

| Index | Register | Access |
|---|---|---|
| 0 | synchronised input level | read only |
| 1 | output value | read/write |
| 2 | drive enable, 1 = drive | read/write |
| 3 | rising-edge enable | read/write |
| 4 | falling-edge enable | read/write |
| 5 | edge events | read, write 1 to clear |
| 6 | alternate-function select, 1 = peripheral | read/write |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0 on every pin (all pins are inputs) and `irq` is 0.
- R2: An input change is visible in the level register (index 0) two rising clock edges after it is applied, and not after only one.
- R3: For a pin with alternate select 0, `pin_out` equals its output-value bit (index 1) and `pin_oe` equals its drive-enable bit (index 2).
- R4: With rising enable set (index 3), a 0-to-1 transition of the synchronised input sets the pin's event bit (index 5) three clock edges after the pin changes. A 1-to-0 transition with only rising enable set leaves the bit at 0.
- R5: With falling enable set (index 4), a 1-to-0 transition sets the event bit. A 0-to-1 transition with only falling enable set leaves the bit at 0.
- R6: With both enables set, both directions of transition set the event bit.
- R7: Event bits stay set until software writes 1 to them at index 5. Writing 0 to an event bit leaves it unchanged.
- R8: If a clearing write and a new detected edge on the same pin happen in the same cycle, the event bit stays set.
- R9: `irq` is 1 exactly when some pin has its event bit set together with at least one of its edge enables. Clearing that pin's enables masks `irq` but keeps the event bit set.
- R10: A pin with alternate select 1 (index 6) takes `pin_out` from `alt_out` and `pin_oe` from `alt_oe`. The other pins keep their register values. `alt_in` carries the synchronised level of every pin.
- R11: Bits at and above NPINS (28) read 0, and a read of an unused index (7 to 15) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_sel | input | 1 | register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from address |
| pin_in | input | 28 | raw pin input levels |
| pin_out | output | 28 | pin output values |
| pin_oe | output | 28 | pin drive enables |
| alt_out | input | 28 | peripheral output values |
| alt_oe | input | 28 | peripheral drive enables |
| alt_in | output | 28 | synchronised levels for the peripheral |
| irq | output | 1 | combined edge interrupt |

## Verification
A stuck or skipped synchroniser stage shows as a level that appears one edge early or never arrives. A missing previous-value flop makes edge events appear on the wrong direction, or without any edge, three cycles after a pin moves. A wrong clear priority shows at once as an event bit that reads 0 after a clearing write that coincided with an edge. A broken mask appears as `irq` disagreeing with the enable registers in the same cycle they are written. Mis-routed multiplexing is visible on `pin_out` and `pin_oe` one cycle after the select write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] IDX_LEVEL = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_OUT   = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_DRIVE = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_RISE  = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_FALL  = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_EVENT = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_ALT   = 4'd6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] st_d;
    if (g == 0) begin : g_first
      assign st_d = d;
    end else begin : g_rest
      assign st_d = st_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= '0;
      else        st_q[g] <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q, stat_q, stat_d, rise_hit, fall_hit;

  always_comb begin
    rise_hit = lvl & ~prev_q & rise_en;
    fall_hit = ~lvl & prev_q & fall_en;
    // a new edge wins over a simultaneous clear
    stat_d   = (stat_q & ~clr) | rise_hit | fall_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
  assign irq    = |(stat_q & (rise_en | fall_en));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W  = 28,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      out_val,
  output logic [W-1:0]      drive,
  output logic [W-1:0]      rise_en,
  output logic [W-1:0]      fall_en,
  output logic [W-1:0]      alt_sel,
  output logic [W-1:0]      clr
);
  localparam int unsigned NREG = 5;
  localparam logic [ADDR_W-1:0] RW_IDX [NREG] = '{IDX_OUT, IDX_DRIVE, IDX_RISE, IDX_FALL, IDX_ALT};

  logic [W-1:0] reg_q [NREG];
  logic [W-1:0] reg_d [NREG];
  logic         wr_go;

  assign wr_go = bus_sel & bus_wr;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic we;
    assign we = wr_go & (bus_addr == RW_IDX[g]);
    always_comb reg_d[g] = we ? bus_wdata[W-1:0] : reg_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else        reg_q[g] <= reg_d[g];
    end
  end

  assign out_val = reg_q[0];
  assign drive   = reg_q[1];
  assign rise_en = reg_q[2];
  assign fall_en = reg_q[3];
  assign alt_sel = reg_q[4];
  assign clr     = (wr_go && bus_addr == IDX_EVENT) ? bus_wdata[W-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_LEVEL: bus_rdata[W-1:0] = level;
      IDX_OUT:   bus_rdata[W-1:0] = reg_q[0];
      IDX_DRIVE: bus_rdata[W-1:0] = reg_q[1];
      IDX_RISE:  bus_rdata[W-1:0] = reg_q[2];
      IDX_FALL:  bus_rdata[W-1:0] = reg_q[3];
      IDX_EVENT: bus_rdata[W-1:0] = status;
      IDX_ALT:   bus_rdata[W-1:0] = reg_q[4];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 28,
  parameter int unsigned DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq
);
  logic [NPINS-1:0] level, status, out_val, drive, rise_en, fall_en, alt_sel, clr;

  gpio_sync #(.W(NPINS), .STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level)
  );

  gpio_regs #(.W(NPINS), .DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level(level), .status(status),
    .out_val(out_val), .drive(drive), .rise_en(rise_en),
    .fall_en(fall_en), .alt_sel(alt_sel), .clr(clr)
  );

  gpio_edge #(.W(NPINS)) i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(level),
    .rise_en(rise_en), .fall_en(fall_en), .clr(clr),
    .status(status), .irq(irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pin_out[p] = alt_sel[p] ? alt_out[p] : out_val[p];
    assign pin_oe[p]  = alt_sel[p] ? alt_oe[p]  : drive[p];
  end

  assign alt_in = level;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 28,
  parameter int unsigned DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  level,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  rise_en,
  input logic [NPINS-1:0]  fall_en,
  input logic              irq
);
  logic [1:0]       age_q;
  logic [NPINS-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign clr_mask = (bus_sel && bus_wr && bus_addr == IDX_EVENT) ? bus_wdata[NPINS-1:0] : '0;

  // R2: level is the pin input delayed by two edges
  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (level == $past(pin_in, 2)));

  // R7: an event bit only drops after a clearing write to it
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_mask) & ~status) == '0));

  // R4: a newly set event bit had an enable in the previous cycle
  p_set_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0));

  // R9: the interrupt only falls after a register write
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_sel && bus_wr));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_in(pin_in),
  .level(level), .status(status), .rise_en(rise_en), .fall_en(fall_en),
  .irq(irq)
);

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;
  localparam int N = 28;
  localparam logic [31:0] PMASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] pin_in, pin_out, pin_oe, alt_out, alt_oe, alt_in;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_edge_port i_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(a[3:0], d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 pin_oe reset", {4'h0, pin_oe}, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk);
    pin_in[3] = 1'b1;
    @(posedge clk);
    rd(4'd0, d);
    check("R2 level after one edge", {31'h0, d[3]}, 32'h0);
    rd(4'd0, d);
    check("R2 level after two edges", {31'h0, d[3]}, 32'h1);
    settle_pins('0);
  endtask

  task automatic t_output;
    wr(4'd1, 32'h0A5A_5A5A);
    wr(4'd2, 32'h00F0_F0F0);
    @(negedge clk);
    check("R3 pin_out", {4'h0, pin_out}, 32'h0A5A_5A5A);
    check("R3 pin_oe", {4'h0, pin_oe}, 32'h00F0_F0F0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(4'd3, 32'h1);
    settle_pins(28'h1);
    rd(4'd5, d);
    check("R4 rising sets event", d, 32'h1);
    check("R9 irq on enabled event", {31'h0, irq}, 32'h1);
    wr(4'd5, 32'h1);
    settle_pins(28'h0);
    rd(4'd5, d);
    check("R4 falling ignored with rise only", d, 32'h0);
    check("R9 irq low after clear", {31'h0, irq}, 32'h0);
    wr(4'd3, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(4'd4, 32'h2);
    settle_pins(28'h2);
    rd(4'd5, d);
    check("R5 rising ignored with fall only", d, 32'h0);
    settle_pins(28'h0);
    rd(4'd5, d);
    check("R5 falling sets event", d, 32'h2);
    wr(4'd5, 32'h2);
    wr(4'd4, 32'h0);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(4'd3, 32'h4);
    wr(4'd4, 32'h4);
    settle_pins(28'h4);
    rd(4'd5, d);
    check("R6 both: rising", d, 32'h4);
    wr(4'd5, 32'h4);
    rd(4'd5, d);
    check("R7 write one clears", d, 32'h0);
    settle_pins(28'h0);
    rd(4'd5, d);
    check("R6 both: falling", d, 32'h4);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(4'd3, 32'h5);
    settle_pins(28'h1);
    rd(4'd5, d);
    check("R7 two events pending", d, 32'h5);
    wr(4'd5, 32'h0);
    rd(4'd5, d);
    check("R7 write zero keeps events", d, 32'h5);
    wr(4'd5, 32'h1);
    rd(4'd5, d);
    check("R7 clear only written bit", d, 32'h4);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    // bit2 set, both edges enabled, pin2 low; now rise pin2 and clear together
    @(negedge clk);
    pin_in = 28'h5;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(4'd5, d);
    check("R8 edge during clear keeps bit", d & 32'h4, 32'h4);
    wr(4'd5, 32'h4);
    rd(4'd5, d);
    check("R8 plain clear afterwards", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    settle_pins(28'h1);
    check("R9 irq before mask", {31'h0, irq}, 32'h1);
    wr(4'd3, 32'h0);
    wr(4'd4, 32'h0);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rd(4'd5, d);
    check("R9 event kept while masked", d, 32'h4);
    wr(4'd4, 32'h4);
    check("R9 irq unmasked", {31'h0, irq}, 32'h1);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_alt;
    @(negedge clk);
    alt_out = 28'h00000F0;
    alt_oe  = 28'h0000030;
    wr(4'd6, 32'h0000_00F0);
    @(negedge clk);
    check("R10 pin_out mixed", {4'h0, pin_out}, 32'h0A5A_5AFA);
    check("R10 pin_oe mixed", {4'h0, pin_oe}, 32'h00F0_F030);
    settle_pins(28'h8000001);
    check("R10 alt_in level", {4'h0, alt_in}, 32'h0800_0001);
    wr(4'd6, 32'h0);
    @(negedge clk);
    check("R10 released pins", {4'h0, pin_out}, 32'h0A5A_5A5A);
  endtask

  task automatic t_width;
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d);
    check("R11 upper bits read zero", d, PMASK);
    rd(4'd9, d);
    check("R11 unused index reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_sync();
    t_output();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_collide();
    t_mask();
    t_alt();
    t_width();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule